// File: doc/BRIEF.md
# Interval Timer with Port-Bit Output

This block is a down-counting interval timer of configurable width (16 bits by default). Its period comes from a reload latch, and a small control register selects its behaviour. Software writes the latch and the control register through a single write strobe, and a select bit chooses which of the two is written. While the timer runs, the counter drops by one on every clock in which the count-enable tick is high. When a tick arrives with the counter at zero, the counter reloads from the latch. The same event raises a one-cycle underflow status pulse at once, and the interrupt request follows one cycle later.

A start from the stopped state goes through a short pipeline. A start with force load first loads the counter from the latch, then waits one cycle, then counts. A start without force load only waits one cycle, then counts from whatever value the counter already holds. One-shot mode clears the start bit on the first underflow. A toggle flip-flop is set to 1 each time the timer starts and flips on every underflow. When the port-output enable is set, the timer drives one parallel-port bit: either the toggle level or a one-cycle pulse that lines up with the interrupt cycle. When the enable is clear, the port bit passes straight through.

Top module: `ivl_timer`

## Requirements
- R1: After reset, the counter and the latch read all ones, the control bits are clear, the timer is stopped, uflow and irq are 0, port_oe is 0 and port_out equals port_in.
- R2: While counting, in a cycle with tick=1 and no control write, the counter decreases by one. With tick=0 it holds its value.
- R3: A tick with the counter at 0 reloads the counter from the latch and makes uflow high for one cycle. With latch value L and tick held high, underflows repeat every L+1 cycles.
- R4: irq is high exactly in the cycle after each uflow cycle.
- R5: A control write (wr_sel=1) with bit 0 (start) and bit 4 (force load) both set loads the counter from the latch one cycle later. It then waits one cycle, so with tick held high the first uflow appears L+3 cycles after the write edge.
- R6: A start without force load keeps the counter value C. With tick held high, the first uflow appears C+2 cycles after the write edge.
- R7: A latch write (wr_sel=0) while the timer is stopped changes the latch only. The counter output keeps its value.
- R8: With control bit 3 (one-shot) set, the first underflow clears the start bit and stops the timer. The counter then keeps the latch value and no further uflow occurs.
- R9: A start from the stopped state sets the toggle to 1, and every underflow inverts it.
- R10: Control bit 1 drives port_oe. When it is 0, port_out equals port_in. When it is 1, port_out is the toggle if control bit 2 is 1, and the irq pulse if control bit 2 is 0.
- R11: A control write with bit 0 clear stops the timer. The counter then holds its value and no uflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the latch, 1 selects the control register |
| wr_data | input | W | Write data; control uses bits 4:0 |
| tick | input | 1 | Count enable |
| port_in | input | 1 | Normal value of the shared port bit |
| count | output | W | Current counter value |
| uflow | output | 1 | Underflow status pulse |
| irq | output | 1 | Interrupt request, one cycle after uflow |
| port_out | output | 1 | Port bit after the timer override |
| port_oe | output | 1 | Timer drives the port bit |

## Verification
Latch values 0 to 7 are swept with force-load starts in toggle mode. The measured delay to the first underflow separates the load-wait-count pipeline from a plain wait. The spacing of later underflows confirms the reload period, and the port level before and after each underflow exposes the forced-high start and the inversion. A pulse-mode run compares port_out with irq every cycle, and in the same run tick gating and the decrement sequence are checked against arithmetic. A one-shot run is followed by a start without force load from the reloaded counter, which separates the two start paths and shows that a latch write while stopped leaves the counter alone. Runs with the port enable off toggle port_in to show the pass-through.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  typedef enum logic [2:0] {
    ST_STOP      = 3'd0,
    ST_LOAD_STOP = 3'd1,
    ST_LOAD_WAIT = 3'd2,
    ST_WAIT      = 3'd3,
    ST_COUNT     = 3'd4
  } tstate_e;

  // control field positions
  localparam int CB_START   = 0;
  localparam int CB_PEN     = 1;
  localparam int CB_TOGMODE = 2;
  localparam int CB_ONESHOT = 3;
  localparam int CB_FLOAD   = 4;
  localparam int CTRL_W     = 4;  // stored bits; force load is a strobe
endpackage

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
  import ivl_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [W-1:0]      wr_data,
  input  logic              oneshot_stop,
  output logic [W-1:0]      latch_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ctrl_wr,
  output logic              new_start,
  output logic              new_force
);
  logic [W-1:0]      latch_d;
  logic [CTRL_W-1:0] ctrl_d;
  logic              latch_wr;

  assign latch_wr  = wr_en & ~wr_sel;
  assign ctrl_wr   = wr_en & wr_sel;
  assign new_start = wr_data[CB_START];
  assign new_force = wr_data[CB_FLOAD];

  always_comb begin
    latch_d = latch_q;
    if (latch_wr) latch_d = wr_data;
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d = wr_data[CTRL_W-1:0];
    end else if (oneshot_stop) begin
      ctrl_d[CB_START] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
      ctrl_q  <= '0;
    end else begin
      latch_q <= latch_d;
      ctrl_q  <= ctrl_d;
    end
  end
endmodule

// File: rtl/ivl_timer_seq.sv
module ivl_timer_seq
  import ivl_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [W-1:0]      latch_q,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              ctrl_wr,
  input  logic              new_start,
  input  logic              new_force,
  output logic [W-1:0]      cnt_q,
  output tstate_e           st_q,
  output logic              uf_q,
  output logic              irq_q,
  output logic              tog_q,
  output logic              oneshot_stop
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  tstate_e      st_d;
  logic [W-1:0] cnt_d;
  logic         uf_d, irq_d, tog_d;
  logic         stopped;

  assign stopped = (st_q == ST_STOP) || (st_q == ST_LOAD_STOP);

  always_comb begin
    st_d         = st_q;
    cnt_d        = cnt_q;
    tog_d        = tog_q;
    uf_d         = 1'b0;
    irq_d        = uf_q;
    oneshot_stop = 1'b0;
    if (ctrl_wr) begin
      if (new_start) begin
        if (stopped) tog_d = 1'b1;
        if (new_force)    st_d = ST_LOAD_WAIT;
        else if (stopped) st_d = ST_WAIT;
      end else begin
        st_d = new_force ? ST_LOAD_STOP : ST_STOP;
      end
    end else begin
      unique case (st_q)
        ST_LOAD_STOP: begin
          cnt_d = latch_q;
          st_d  = ST_STOP;
        end
        ST_LOAD_WAIT: begin
          cnt_d = latch_q;
          st_d  = ST_WAIT;
        end
        ST_WAIT: st_d = ST_COUNT;
        ST_COUNT: begin
          if (tick) begin
            if (cnt_q == ZERO) begin
              cnt_d = latch_q;
              uf_d  = 1'b1;
              tog_d = ~tog_q;
              if (ctrl_q[CB_ONESHOT]) begin
                st_d         = ST_STOP;
                oneshot_stop = 1'b1;
              end
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_STOP;
      cnt_q <= '1;
      uf_q  <= 1'b0;
      irq_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      uf_q  <= uf_d;
      irq_q <= irq_d;
      tog_q <= tog_d;
    end
  end
endmodule

// File: rtl/ivl_timer_pinmux.sv
module ivl_timer_pinmux
  import ivl_timer_pkg::*;
(
  input  logic              port_in,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              tog_q,
  input  logic              irq_q,
  output logic              port_out,
  output logic              port_oe
);
  logic timer_level;

  always_comb begin
    timer_level = ctrl_q[CB_TOGMODE] ? tog_q : irq_q;
    port_oe     = ctrl_q[CB_PEN];
    port_out    = ctrl_q[CB_PEN] ? timer_level : port_in;
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  input  logic         port_in,
  output logic [W-1:0] count,
  output logic         uflow,
  output logic         irq,
  output logic         port_out,
  output logic         port_oe
);
  logic [W-1:0]      latch_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr, new_start, new_force, oneshot_stop, tog_q;
  tstate_e           st_q;

  ivl_timer_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .oneshot_stop(oneshot_stop), .latch_q(latch_q),
    .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .new_start(new_start),
    .new_force(new_force)
  );

  ivl_timer_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .latch_q(latch_q),
    .ctrl_q(ctrl_q), .ctrl_wr(ctrl_wr), .new_start(new_start),
    .new_force(new_force), .cnt_q(count), .st_q(st_q), .uf_q(uflow),
    .irq_q(irq), .tog_q(tog_q), .oneshot_stop(oneshot_stop)
  );

  ivl_timer_pinmux u_mux (
    .port_in(port_in), .ctrl_q(ctrl_q), .tog_q(tog_q), .irq_q(irq),
    .port_out(port_out), .port_oe(port_oe)
  );
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
  import ivl_timer_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              tick,
  input logic              port_in,
  input logic [W-1:0]      count,
  input logic [W-1:0]      latch,
  input logic [CTRL_W-1:0] ctrl,
  input tstate_e           st,
  input logic              uflow,
  input logic              irq,
  input logic              port_out,
  input logic              port_oe
);
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_COUNT && tick && !wr_en && count != '0)
      |=> count == $past(count) - W'(1));

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && !$past(wr_en)) |-> count == latch);

  a_r4_irq_after: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> irq);

  a_r4_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(uflow));

  a_r8_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && $past(ctrl[CB_ONESHOT]) && !$past(wr_en))
      |-> (!ctrl[CB_START] && st == ST_STOP));

  a_r9_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow && port_oe && ctrl[CB_TOGMODE] && !$past(wr_en))
      |-> port_out != $past(port_out));

  a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    !port_oe |-> port_out == port_in);
endmodule

bind ivl_timer ivl_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .port_in(port_in),
  .count(count), .latch(latch_q), .ctrl(ctrl_q), .st(st_q), .uflow(uflow),
  .irq(irq), .port_out(port_out), .port_oe(port_oe)
);

// File: tb/ivl_timer_tb.sv
module ivl_timer_tb;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic         wr_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         tick = 1'b1;
  logic         port_in = 1'b0;
  logic [W-1:0] count;
  logic         uflow, irq, port_out, port_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ivl_timer #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick(tick), .port_in(port_in), .count(count),
    .uflow(uflow), .irq(irq), .port_out(port_out), .port_oe(port_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // write lands on the edge between two falling edges
  task automatic wr(input bit sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_uflow(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!uflow && k < 300);
  endtask

  initial begin
    int k;
    int c0;
    int prev;
    int e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(count == 16'hFFFF, "R1 count", int'(count), 65535);
    chk(uflow == 1'b0 && irq == 1'b0, "R1 flags", int'({uflow, irq}), 0);
    chk(port_oe == 1'b0, "R1 port_oe", int'(port_oe), 0);
    port_in = 1'b1; #1;
    chk(port_out == 1'b1, "R1 passthru", int'(port_out), 1);
    port_in = 1'b0; #1;
    chk(port_out == 1'b0, "R1 passthru", int'(port_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(count == 16'hFFFF, "R1 count after release", int'(count), 65535);

    // sweep latch values, force-load start, toggle mode
    for (int L = 0; L < 8; L++) begin
      c0 = int'(count);
      wr(1'b0, L);
      chk(int'(count) == c0, "R7 latch write while stopped", int'(count), c0);
      wr(1'b1, 'h17);
      chk(port_out == 1'b1, "R9 toggle forced on start", int'(port_out), 1);
      chk(port_oe == 1'b1, "R10 port_oe", int'(port_oe), 1);
      wait_uflow(k);
      chk(k == L + 3, "R5 first uflow delay", k, L + 3);
      chk(int'(count) == L, "R3 reload value", int'(count), L);
      chk(port_out == 1'b0, "R9 toggle inverted", int'(port_out), 0);
      wait_uflow(k);
      chk(k == L + 1, "R3 period", k, L + 1);
      chk(port_out == 1'b1, "R9 toggle inverted again", int'(port_out), 1);
      @(negedge clk);
      chk(irq == 1'b1, "R4 irq after uflow", int'(irq), 1);
      chk(uflow == (L == 0), "R3 uflow one cycle", int'(uflow), int'(L == 0));
      wr(1'b1, 'h06);
      c0 = int'(count);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(int'(count) == c0 && !uflow, "R11 stopped holds", int'(count), c0);
      end
    end

    // pulse mode, L=3
    wr(1'b0, 3);
    wr(1'b1, 'h13);
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      chk(port_out == irq, "R10 pulse mode follows irq", int'(port_out), int'(irq));
    end
    for (int i = 0; i < 8; i++) begin
      prev = int'(count);
      @(negedge clk);
      e = (prev == 0) ? 3 : prev - 1;
      chk(int'(count) == e, "R2 decrement", int'(count), e);
    end
    tick = 1'b0;
    @(negedge clk);
    c0 = int'(count);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(int'(count) == c0 && !uflow, "R2 tick low holds", int'(count), c0);
    end
    tick = 1'b1;
    @(negedge clk);
    e = (c0 == 0) ? 3 : c0 - 1;
    chk(int'(count) == e, "R2 tick resumes", int'(count), e);

    // port enable off, still running
    wr(1'b1, 'h01);
    for (int i = 0; i < 6; i++) begin
      port_in = i[0];
      @(negedge clk);
      chk(port_out == port_in && !port_oe, "R10 disabled passthru",
          int'(port_out), int'(port_in));
    end

    // one-shot, then start without force
    wr(1'b1, 'h00);
    wr(1'b0, 4);
    wr(1'b1, 'h1F);
    wait_uflow(k);
    chk(k == 7, "R5 one-shot first uflow", k, 7);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(count == 4 && !uflow, "R8 one-shot stopped", int'(count), 4);
    end
    wr(1'b0, 2);
    chk(count == 4, "R7 latch write keeps count", int'(count), 4);
    wr(1'b1, 'h0F);
    chk(port_out == 1'b1, "R9 toggle forced on restart", int'(port_out), 1);
    wait_uflow(k);
    chk(k == 6, "R6 start without force", k, 6);
    chk(count == 2, "R6 reload new latch", int'(count), 2);
    repeat (6) begin
      @(negedge clk);
      chk(!uflow, "R8 no further uflow", int'(uflow), 0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule